// File: doc/BRIEF.md
# Transmit Frame Pulse Generator with Multiframe Marking

This block drives a one-bit marker beside a transmit SDH byte stream. The stream runs at either the STM-1 or the STM-0 byte rate. The marker flags the first path-overhead byte (J1) and the section trace byte, called C1 here, in every frame. When multiframe marking is enabled, it also flags the V1 byte, but only on one frame out of every four. An external 2 kHz sync input sets which frame that is. Several devices driven by the same sync therefore flag V1 on the same frame, and their tributary multiframes stay aligned.

The block keeps its own row and column position. A frame-start strobe aligns that position: the strobe is sampled on the clock edge before the first byte of a frame. Upstream pointer logic supplies the J1 and V1 positions as row and column values. The block takes these positions, together with the rate and mode selects, at each frame start. It also outputs a 2-bit multiframe phase that counts frames within the four-frame cycle.

Top module: `tx_frame_pulse_gen`

## Requirements
- R1: After reset, `fp_out` is 0 and `mf_phase` is 0. `fp_out` stays 0 until the first `frame_start` has been sampled.
- R2: A `frame_start` sampled high on a clock edge makes the following cycle byte (row 0, column 0). Bytes then run column by column, then row by row, across 9 rows. A row has 270 columns when the rate latched for the frame is 0 (STM-1) and 90 columns when it is 1 (STM-0). `fp_out` is high on byte (row 0, column 6) at STM-1 and on byte (row 0, column 2) at STM-0.
- R3: `fp_out` is high on the byte whose row and column equal the J1 position latched for the frame, in every frame.
- R4: When multiframe mode is latched for the frame and `mf_phase` is 0, `fp_out` is also high on the byte at the latched V1 position.
- R5: When multiframe mode is off, only the C1 and J1 bytes are flagged, giving exactly two pulses per frame.
- R6: V2, V3 and V4 are never flagged. With distinct C1, J1 and V1 positions in multiframe mode, each four-frame cycle carries exactly nine pulses, and every frame other than phase 0 carries exactly two.
- R7: `mf_phase` changes only in the cycle after a sampled `frame_start`. At each frame start it advances by one, modulo 4.
- R8: A rising edge of `sync_2k` sampled on or before the edge that samples a `frame_start` forces `mf_phase` to 0 at that frame start, instead of advancing it.
- R9: `rate_lo`, `sf_en` and the J1 and V1 row and column inputs are sampled only with `frame_start`. A change during a frame first affects the next frame.
- R10: Each pulse is one byte-clock cycle long and falls in the same cycle as the byte it flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rate_lo | input | 1 | 0: 270 columns (STM-1), 1: 90 columns (STM-0) |
| sf_en | input | 1 | Enables V1 marking once per four-frame multiframe |
| sync_2k | input | 1 | 2 kHz multiframe sync, already synchronous to clk |
| frame_start | input | 1 | High one cycle before byte (row 0, column 0) |
| j1_row | input | 4 | Row of the J1 byte |
| j1_col | input | 9 | Column of the J1 byte |
| v1_row | input | 4 | Row of the V1 byte |
| v1_col | input | 9 | Column of the V1 byte |
| fp_out | output | 1 | Frame pulse marking C1, J1 and (multiframe) V1 |
| mf_phase | output | 2 | Multiframe phase, 0 on the V1-marked frame |

## Verification
The assertions check the following on every cycle:
- `fp_out` stays quiet until the first frame start.
- `mf_phase` holds between frame starts.
- At each frame start, the phase either steps by one or returns to 0.
- No frame carries more than three pulses.

The bench's scenarios cover the rest:
- the exact byte each pulse lands on at both rates;
- the V1 pulse appearing only on phase 0;
- the sync forcing phase 0 on the right frame, including when the sync edge and the frame-start strobe share a clock edge;
- configuration changes that wait for the next frame.

// File: rtl/tx_frame_pulse_gen.sv
module tx_frame_pulse_gen #(
  parameter int ROWS      = 9,
  parameter int COLS_HI   = 270,
  parameter int COLS_LO   = 90,
  parameter int C1_COL_HI = 6,
  parameter int C1_COL_LO = 2,
  parameter int RW        = $clog2(ROWS),
  parameter int CW        = $clog2(COLS_HI)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate_lo,
  input  logic          sf_en,
  input  logic          sync_2k,
  input  logic          frame_start,
  input  logic [RW-1:0] j1_row,
  input  logic [CW-1:0] j1_col,
  input  logic [RW-1:0] v1_row,
  input  logic [CW-1:0] v1_col,
  output logic          fp_out,
  output logic [1:0]    mf_phase
);

  logic [RW-1:0] row_q, j1r_l, v1r_l;
  logic [CW-1:0] col_q, j1c_l, v1c_l;
  logic          rate_l, sf_l, locked, sync_q, pend;
  logic [1:0]    mf_q;

  wire           rise     = sync_2k & ~sync_q;
  wire [CW-1:0]  last_col = rate_l ? CW'(COLS_LO - 1) : CW'(COLS_HI - 1);
  wire [CW-1:0]  c1_col   = rate_l ? CW'(C1_COL_LO) : CW'(C1_COL_HI);
  wire           row_end  = (col_q == last_col);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q  <= '0;
      col_q  <= '0;
      j1r_l  <= '0;
      j1c_l  <= '0;
      v1r_l  <= '0;
      v1c_l  <= '0;
      rate_l <= 1'b0;
      sf_l   <= 1'b0;
      locked <= 1'b0;
      sync_q <= 1'b0;
      pend   <= 1'b0;
      mf_q   <= '0;
    end else begin
      sync_q <= sync_2k;
      if (frame_start) begin
        row_q  <= '0;
        col_q  <= '0;
        locked <= 1'b1;
        rate_l <= rate_lo;
        sf_l   <= sf_en;
        j1r_l  <= j1_row;
        j1c_l  <= j1_col;
        v1r_l  <= v1_row;
        v1c_l  <= v1_col;
        mf_q   <= (pend | rise) ? 2'd0 : mf_q + 2'd1;
        pend   <= 1'b0;
      end else begin
        pend  <= pend | rise;
        col_q <= row_end ? '0 : col_q + 1'b1;
        if (row_end)
          row_q <= (row_q == RW'(ROWS - 1)) ? '0 : row_q + 1'b1;
      end
    end
  end

  wire c1_hit = (row_q == '0) && (col_q == c1_col);
  wire j1_hit = (row_q == j1r_l) && (col_q == j1c_l);
  wire v1_hit = sf_l && (mf_q == 2'd0) && (row_q == v1r_l) && (col_q == v1c_l);

  assign fp_out   = locked & (c1_hit | j1_hit | v1_hit);
  assign mf_phase = mf_q;

endmodule

// File: rtl/fp_pulse_checks.sv
module fp_pulse_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_start,
  input logic       fp_out,
  input logic [1:0] mf_phase
);

  logic       seen;
  logic [2:0] pcnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen <= 1'b0;
      pcnt <= '0;
    end else begin
      if (frame_start) seen <= 1'b1;
      if (frame_start) pcnt <= '0;
      else if (fp_out && pcnt != 3'd7) pcnt <= pcnt + 3'd1;
    end
  end

  p_quiet_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !fp_out);

  p_phase_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> $stable(mf_phase));

  p_phase_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(frame_start) |-> (mf_phase == 2'd0 || mf_phase == $past(mf_phase) + 2'd1));

  p_pulse_budget_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= 3'd3);

endmodule

bind tx_frame_pulse_gen fp_pulse_checks u_chk (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
  .fp_out(fp_out), .mf_phase(mf_phase)
);

// File: tb/sim_tx_frame_pulse_gen.sv
module sim_tx_frame_pulse_gen;

  logic       clk = 1'b0;
  logic       rst_n, rate_lo, sf_en, sync_2k, frame_start;
  logic [3:0] j1_row, v1_row;
  logic [8:0] j1_col, v1_col;
  logic       fp_out;
  logic [1:0] mf_phase;

  always #5 clk = ~clk;

  tx_frame_pulse_gen u0 (
    .clk(clk), .rst_n(rst_n), .rate_lo(rate_lo), .sf_en(sf_en),
    .sync_2k(sync_2k), .frame_start(frame_start),
    .j1_row(j1_row), .j1_col(j1_col), .v1_row(v1_row), .v1_col(v1_col),
    .fp_out(fp_out), .mf_phase(mf_phase)
  );

  typedef struct packed {
    logic       rate;
    logic       sf;
    logic [3:0] j1r;
    logic [8:0] j1c;
    logic [3:0] v1r;
    logic [8:0] v1c;
    logic [3:0] nfr;
    logic [11:0] sync_at;
  } vec_t;

  localparam logic [11:0] NO_SYNC = 12'hFFF;
  localparam vec_t VEC [0:3] = '{
    '{1'b0, 1'b1, 4'd0, 9'd10, 4'd3, 9'd40,  4'd5, 12'd1000},
    '{1'b0, 1'b0, 4'd2, 9'd100, 4'd3, 9'd40, 4'd2, NO_SYNC},
    '{1'b1, 1'b1, 4'd1, 9'd50, 4'd5, 9'd89,  4'd5, 12'd809},
    '{1'b1, 1'b1, 4'd8, 9'd89, 4'd0, 9'd0,   4'd4, NO_SYNC}
  };

  int checks = 0, failures = 0;
  logic m_rate, m_sf, m_pend;
  logic [3:0] m_j1r, m_v1r;
  logic [8:0] m_j1c, m_v1c;
  logic [1:0] m_mf;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic boundary(input logic rise);
    m_mf   = (m_pend | rise) ? 2'd0 : m_mf + 2'd1;
    m_pend = 1'b0;
    m_rate = rate_lo; m_sf = sf_en;
    m_j1r = j1_row; m_j1c = j1_col; m_v1r = v1_row; m_v1c = v1_col;
  endtask

  task automatic run_vec(input int v);
    rate_lo = VEC[v].rate; sf_en = VEC[v].sf;
    j1_row = VEC[v].j1r; j1_col = VEC[v].j1c;
    v1_row = VEC[v].v1r; v1_col = VEC[v].v1c;
    for (int f = 0; f < int'(VEC[v].nfr); f++) begin
      int nc = m_rate ? 90 : 270;
      int c1 = m_rate ? 2 : 6;
      int pulses = 0, bad = 0, bad_i = 0, bad_exp = 0;
      int exp_pulses = 2 + ((m_sf && m_mf == 2'd0) ? 1 : 0);
      chk(mf_phase == m_mf, "R7 R8 phase at frame start", mf_phase, m_mf);
      for (int i = 0; i < 9 * nc; i++) begin
        int r = i / nc;
        int c = i % nc;
        logic e, ns, rise;
        e = (r == 0 && c == c1) || (r == m_j1r && c == m_j1c) ||
            (m_sf && m_mf == 2'd0 && r == m_v1r && c == m_v1c);
        if (fp_out !== e) begin
          if (bad == 0) begin bad_i = i; bad_exp = e; end
          bad++;
        end
        if (fp_out) pulses++;
        ns = sync_2k;
        if (f == 0 && i == int'(VEC[v].sync_at)) ns = 1'b1;
        else if (f == 1 && i == 20) ns = 1'b0;
        rise = ns & ~sync_2k;
        sync_2k = ns;
        frame_start = (i == 9 * nc - 1);
        if (frame_start) boundary(rise);
        else m_pend = m_pend | rise;
        @(posedge clk); @(negedge clk);
      end
      frame_start = 1'b0;
      chk(bad == 0, "R2 R3 R4 R9 R10 pulse position", bad_i, bad_exp);
      chk(pulses == exp_pulses, "R5 R6 pulses per frame", pulses, exp_pulses);
    end
  endtask

  initial begin
    rst_n = 1'b0; rate_lo = 1'b0; sf_en = 1'b0; sync_2k = 1'b0; frame_start = 1'b0;
    j1_row = '0; j1_col = 9'd10; v1_row = '0; v1_col = 9'd40;
    m_pend = 1'b0; m_mf = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fp_out == 1'b0, "R1 reset pulse", fp_out, 0);
    chk(mf_phase == 2'd0, "R1 reset phase", mf_phase, 0);
    rst_n = 1'b1;
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(posedge clk); @(negedge clk);
        if (fp_out) seen++;
      end
      chk(seen == 0, "R1 no pulse before frame start", seen, 0);
    end
    rate_lo = VEC[0].rate; sf_en = VEC[0].sf;
    j1_row = VEC[0].j1r; j1_col = VEC[0].j1c; v1_row = VEC[0].v1r; v1_col = VEC[0].v1c;
    frame_start = 1'b1;
    boundary(1'b0);
    @(posedge clk); @(negedge clk);
    frame_start = 1'b0;
    for (int v = 0; v < 4; v++) run_vec(v);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(fp_out == 1'b0, "R1 mid-run reset pulse", fp_out, 0);
    chk(mf_phase == 2'd0, "R1 mid-run reset phase", mf_phase, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule